// File: doc/BRIEF.md
# Privileged Core Start Sequencer

This block brings up the one privileged core that fetches its instructions straight out of the shared RAM. A start request names a target core index, a byte start address and a parameter word. Only requests aimed at the privileged core index are accepted. No program image is copied, because the core already sees the shared RAM as its own memory. The only preparation is zeroing the sixteen special-register shadow longs at the top of the low 512-long window, through the sequencer's write port into the shared RAM.

Once the last shadow long has been written, the core is released. It receives the start address as a long address, its parameter register is loaded, and a one-cycle done pulse marks the release. A control bit in the start address lets software skip the zeroing and set up only the internal registers. A fresh accepted request at any time, including while the core is running or mid-clear, halts the core and starts the sequence again from the first step.

Top module: `pcore_start_seq`

## Requirements
- R1: After reset, `run_o`, `wr_en_o` and `done_o` are 0, and `pc_o` and `par_o` are 0.
- R2: A request with `start_core_i` other than 7 has no effect: `run_o`, `pc_o` and `par_o` keep their values, and no write is issued.
- R3: An accepted request sets `pc_o` to `start_addr_i[14:2]`, the long address. Byte-offset bits [1:0] are discarded.
- R4: An accepted request loads `start_param_i` into `par_o` before the core is released.
- R5: With `start_addr_i[15]` = 0, the cycle after acceptance begins 16 consecutive write cycles. The writes go to long addresses 0x1F0 through 0x1FF in ascending order, each with data 0.
- R6: `run_o` is 0 from the cycle after acceptance until the last shadow write has completed, and it rises in the cycle immediately after the write to 0x1FF.
- R7: With `start_addr_i[15]` = 1, no write is issued. `run_o` is 0 for exactly one cycle after acceptance and then rises.
- R8: `done_o` is high for exactly one cycle, the first cycle in which `run_o` is 1.
- R9: An accepted request during the clear or while running restarts at address 0x1F0 with the new start address and parameter. This holds even in the cycle of the final write, in which case no release or done pulse follows the old sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request strobe |
| start_core_i | input | 3 | Target core index of the request |
| start_addr_i | input | 16 | Byte start address; bit 15 skips the shadow clear |
| start_param_i | input | 32 | Parameter for the core |
| wr_en_o | output | 1 | Write strobe into the shared RAM |
| wr_addr_o | output | 13 | Long address of the write |
| wr_data_o | output | 32 | Write data (zero) |
| run_o | output | 1 | Core released and fetching |
| pc_o | output | 13 | Long start address for the core |
| par_o | output | 32 | Parameter register value for the core |
| done_o | output | 1 | One-cycle release pulse |

## Verification
Two functions can fall into the same cycle: the release that follows the final shadow write, and the acceptance of a new request. The bench provokes this by raising a new start request exactly while the write address shows 0x1FF. It then judges that the next cycle shows address 0x1F0 again, with `run_o` and `done_o` both low and the new start address loaded. A second case raises a request mid-clear at 0x1F5 and expects the count to restart at 0x1F0.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_HOLD  = 2'd2,
    ST_RUN   = 2'd3
  } pcs_state_e;

  typedef struct packed {
    logic go;
    logic skip;
  } pcs_req_t;
endpackage

// File: rtl/pcs_req_decode.sv
module pcs_req_decode
  import pcs_pkg::*;
#(
  parameter int ID_W     = 3,
  parameter int CORE_ID  = 7,
  parameter int SADDR_W  = 16,
  parameter int ADDR_W   = 13,
  parameter int SKIP_BIT = 15
) (
  input  logic               start_i,
  input  logic [ID_W-1:0]    core_i,
  input  logic [SADDR_W-1:0] addr_i,
  output pcs_req_t           req_o,
  output logic [ADDR_W-1:0]  pc_o
);
  logic unused_low;

  assign req_o.go   = start_i && (core_i == ID_W'(CORE_ID));
  assign req_o.skip = addr_i[SKIP_BIT];
  // byte address -> long address
  assign pc_o       = addr_i[ADDR_W+1:2];
  assign unused_low = ^addr_i[1:0];
endmodule

// File: rtl/pcs_clear_ctr.sv
module pcs_clear_ctr #(
  parameter int ADDR_W = 13,
  parameter int CNT    = 16,
  parameter int BASE   = 'h1F0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int CNT_W = (CNT > 1) ? $clog2(CNT) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(CNT - 1));
  assign addr_o = ADDR_W'(BASE) + ADDR_W'(cnt_q);
endmodule

// File: rtl/pcs_fsm.sv
module pcs_fsm
  import pcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pcs_req_t   req_i,
  input  logic       last_i,
  output pcs_state_e state_o,
  output logic       done_o
);
  pcs_state_e st_q, st_d;
  logic       done_q, done_d;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    if (req_i.go) begin
      // restart always wins over a pending release
      st_d = req_i.skip ? ST_HOLD : ST_CLEAR;
    end else begin
      unique case (st_q)
        ST_CLEAR: if (last_i) begin
          st_d   = ST_RUN;
          done_d = 1'b1;
        end
        ST_HOLD: begin
          st_d   = ST_RUN;
          done_d = 1'b1;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign state_o = st_q;
  assign done_o  = done_q;
endmodule

// File: rtl/pcore_start_seq.sv
module pcore_start_seq
  import pcs_pkg::*;
#(
  parameter int ID_W       = 3,
  parameter int CORE_ID    = 7,
  parameter int SADDR_W    = 16,
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 32,
  parameter int SKIP_BIT   = 15,
  parameter int SHADOW_CNT = 16,
  parameter int SHADOW_TOP = 'h200
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ID_W-1:0]    start_core_i,
  input  logic [SADDR_W-1:0] start_addr_i,
  input  logic [DATA_W-1:0]  start_param_i,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               run_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [DATA_W-1:0]  par_o,
  output logic               done_o
);
  localparam int SHADOW_BASE = SHADOW_TOP - SHADOW_CNT;

  pcs_req_t          req;
  logic [ADDR_W-1:0] req_pc;
  logic              last;
  pcs_state_e        state;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] par_q;

  pcs_req_decode #(
    .ID_W(ID_W), .CORE_ID(CORE_ID), .SADDR_W(SADDR_W),
    .ADDR_W(ADDR_W), .SKIP_BIT(SKIP_BIT)
  ) u_dec (
    .start_i(start_i), .core_i(start_core_i), .addr_i(start_addr_i),
    .req_o(req), .pc_o(req_pc)
  );

  pcs_clear_ctr #(
    .ADDR_W(ADDR_W), .CNT(SHADOW_CNT), .BASE(SHADOW_BASE)
  ) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(req.go),
    .en_i(state == ST_CLEAR), .addr_o(wr_addr_o), .last_o(last)
  );

  pcs_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .last_i(last),
    .state_o(state), .done_o(done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      par_q <= '0;
    end else if (req.go) begin
      pc_q  <= req_pc;
      par_q <= start_param_i;
    end
  end

  assign wr_en_o   = (state == ST_CLEAR);
  assign wr_data_o = '0;
  assign run_o     = (state == ST_RUN);
  assign pc_o      = pc_q;
  assign par_o     = par_q;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int ID_W       = 3,
  parameter int CORE_ID    = 7,
  parameter int SADDR_W    = 16,
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 32,
  parameter int SHADOW_CNT = 16,
  parameter int SHADOW_TOP = 'h200
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [ID_W-1:0]    start_core_i,
  input logic [SADDR_W-1:0] start_addr_i,
  input logic               wr_en_o,
  input logic [ADDR_W-1:0]  wr_addr_o,
  input logic [DATA_W-1:0]  wr_data_o,
  input logic               run_o,
  input logic [ADDR_W-1:0]  pc_o,
  input logic               done_o
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(SHADOW_TOP - SHADOW_CNT);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(SHADOW_TOP - 1);

  logic acc;
  assign acc = start_i && (start_core_i == ID_W'(CORE_ID));

  AST_WR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o >= LO && wr_addr_o <= HI)); // R5
  AST_WR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_data_o == '0); // R5
  AST_WR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !acc) |=> (!wr_en_o || wr_addr_o == $past(wr_addr_o) + 1'b1)); // R5
  AST_HALT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !run_o); // R6
  AST_ACC_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !run_o && !done_o); // R9
  AST_ACC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !start_addr_i[SADDR_W-1]) |=> (wr_en_o && wr_addr_o == LO)); // R9
  AST_FOREIGN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc && run_o) |=> run_o); // R2
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(pc_o)); // R3
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> done_o); // R8
  AST_DONE_WITH_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> run_o); // R8
endmodule

bind pcore_start_seq pcs_checker #(
  .ID_W(ID_W), .CORE_ID(CORE_ID), .SADDR_W(SADDR_W), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .SHADOW_CNT(SHADOW_CNT), .SHADOW_TOP(SHADOW_TOP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .start_core_i(start_core_i), .start_addr_i(start_addr_i),
  .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
  .run_o(run_o), .pc_o(pc_o), .done_o(done_o)
);

// File: tb/pcore_start_seq_tb.sv
module pcore_start_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  core = '0;
  logic [15:0] saddr = '0;
  logic [31:0] sparam = '0;
  logic        wr_en, run, done;
  logic [12:0] wr_addr, pc;
  logic [31:0] wr_data, par;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  pcore_start_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_core_i(core),
    .start_addr_i(saddr), .start_param_i(sparam), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .run_o(run), .pc_o(pc),
    .par_o(par), .done_o(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic pulse(input logic [2:0] id, input logic [15:0] a, input logic [31:0] p);
    core = id; saddr = a; sparam = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // from the negedge after acceptance, walk the whole clear and release
  task automatic walk_clear(input string req, input logic [12:0] exp_pc, input logic [31:0] exp_par);
    for (int k = 0; k < 16; k++) begin
      chk("R5", "wr_en", {31'd0, wr_en}, 32'd1);
      chk("R5", "wr_addr", {19'd0, wr_addr}, 32'h1F0 + k);
      chk("R5", "wr_data", wr_data, 32'd0);
      chk("R6", "run during clear", {31'd0, run}, 32'd0);
      @(negedge clk);
    end
    chk("R6", "run after last write", {31'd0, run}, 32'd1);
    chk("R8", "done at release", {31'd0, done}, 32'd1);
    chk("R5", "wr_en after clear", {31'd0, wr_en}, 32'd0);
    chk(req, "pc", {19'd0, pc}, {19'd0, exp_pc});
    chk("R4", "par", par, exp_par);
    @(negedge clk);
    chk("R8", "done single cycle", {31'd0, done}, 32'd0);
    chk("R6", "run holds", {31'd0, run}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R1", "run", {31'd0, run}, 32'd0);
    chk("R1", "wr_en", {31'd0, wr_en}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "pc", {19'd0, pc}, 32'd0);
    chk("R1", "par", par, 32'd0);
  endtask

  task automatic t_clear_start;
    pulse(3'd7, 16'h1238, 32'hCAFE_0001);
    walk_clear("R3", 13'h48E, 32'hCAFE_0001);
  endtask

  task automatic t_foreign;
    pulse(3'd3, 16'h0400, 32'h1111_2222);
    chk("R2", "run kept", {31'd0, run}, 32'd1);
    chk("R2", "no write", {31'd0, wr_en}, 32'd0);
    chk("R2", "pc kept", {19'd0, pc}, 32'h48E);
    chk("R2", "par kept", par, 32'hCAFE_0001);
    @(negedge clk);
    chk("R2", "run still kept", {31'd0, run}, 32'd1);
  endtask

  task automatic t_skip_restart_running;
    pulse(3'd7, 16'hA006, 32'h0000_0BEE);
    chk("R7", "halted one cycle", {31'd0, run}, 32'd0);
    chk("R7", "no write", {31'd0, wr_en}, 32'd0);
    chk("R9", "no done at restart", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R7", "run after hold", {31'd0, run}, 32'd1);
    chk("R8", "done", {31'd0, done}, 32'd1);
    chk("R7", "no write", {31'd0, wr_en}, 32'd0);
    chk("R3", "pc misaligned", {19'd0, pc}, 32'h801);
    chk("R4", "par", par, 32'h0000_0BEE);
    @(negedge clk);
    chk("R8", "done drops", {31'd0, done}, 32'd0);
  endtask

  task automatic t_restart_mid;
    pulse(3'd7, 16'h0100, 32'hAAAA_0000);
    repeat (5) @(negedge clk);
    chk("R5", "mid addr", {19'd0, wr_addr}, 32'h1F5);
    pulse(3'd7, 16'h0204, 32'hBBBB_0000);
    walk_clear("R9", 13'h081, 32'hBBBB_0000);
  endtask

  task automatic t_restart_last;
    pulse(3'd7, 16'h0010, 32'h1);
    repeat (15) @(negedge clk);
    chk("R5", "last addr", {19'd0, wr_addr}, 32'h1FF);
    pulse(3'd7, 16'h0020, 32'h2);
    chk("R9", "no release", {31'd0, run}, 32'd0);
    chk("R9", "no done", {31'd0, done}, 32'd0);
    chk("R9", "pc new", {19'd0, pc}, 32'h8);
    walk_clear("R9", 13'h008, 32'h2);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clear_start();
        t_foreign();
        t_skip_restart_running();
        t_restart_mid();
        t_restart_last();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule